// File: doc/BRIEF.md
# Speculative Retire Buffer

This block is the in-order retirement queue of a speculative out-of-order core. The issue stage claims one slot per instruction, in program order, and gets back the slot index as the instruction's tag. Each slot holds the instruction kind, its destination and the value that will eventually be committed. Functional units return results out of order, addressed by tag. Store addresses arrive on their own port. While a result is waiting to retire it lives only in the slot. Consumers look it up by tag, so the slots serve as the rename registers.

Retirement runs strictly from the oldest slot and handles at most one slot per cycle. A retiring ALU or load result is written to the register file. A retiring store is released to memory. A retiring branch either leaves quietly or, if its writeback reported a misprediction, empties the buffer and presents the correct fetch target. A slot whose writeback reported a fault raises its exception only when it becomes the oldest. At that point it and everything younger are discarded and its tag is reported. Because nothing becomes architecturally visible before retirement, exceptions are precise.

Top module: `spec_retire_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `reg_we`, `mem_we`, `flush_o`, `redirect_valid` and `exc_valid` are all 0.
- R2: Each accepted allocation returns, on `alloc_tag`, the tag one above the previous one, modulo DEPTH. The kind code on `alloc_kind` is 0 for ALU/load, 1 for store and 2 for branch.
- R3: Once DEPTH slots are held, `alloc_ready` is 0 and a request on `alloc_valid` is ignored. It neither moves `alloc_tag` nor alters any held slot.
- R4: Slots retire only in tag order. A younger slot whose result has arrived waits until every older slot has retired.
- R5: An ALU/load slot retires in the cycle after its writeback if it is then the oldest. It drives `reg_we` with `reg_waddr` set to its register number and `reg_wdata` set to its value. No two of `reg_we`, `mem_we`, `redirect_valid` and `exc_valid` are ever high together.
- R6: A store slot retires only when both its data (through the writeback port) and its address (through the store address port) have arrived, in either order. It then drives `mem_we` with that address and data, and does not drive `reg_we`.
- R7: A lookup on `lk_tag` reports `lk_ready` = 1 and the written value on `lk_value` for a held slot whose result has arrived, and `lk_ready` = 0 for a held slot that is still waiting or a slot that is not held.
- R8: A branch whose writeback reported no misprediction retires without any write or flush, and the slots younger than it keep going.
- R9: A branch whose writeback reported a misprediction retires with `flush_o` and `redirect_valid` high and `redirect_pc` equal to its writeback value. No younger slot ever retires, and the next allocated tag is the branch tag plus one.
- R10: A faulting slot, once oldest, drives `exc_valid` with `exc_tag` set to its tag and `flush_o` high, but not `reg_we`. All slots are discarded, and the next allocated tag equals the faulting tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 2 | Kind code of the issuing instruction |
| alloc_dest | input | REG_W | Destination register number (unused for store and branch) |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag the next allocation receives |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | log2(DEPTH) | Slot being written |
| wb_value | input | DATA_W | Result, store data or branch target |
| wb_fault | input | 1 | The instruction faulted |
| wb_mispred | input | 1 | The branch was mispredicted |
| sa_valid | input | 1 | Store address strobe |
| sa_tag | input | log2(DEPTH) | Store slot receiving the address |
| sa_addr | input | ADDR_W | Store address |
| lk_tag | input | NUM_RD*log2(DEPTH) | Operand lookup tags, port 0 in the low bits |
| lk_ready | output | NUM_RD | Lookup result is available |
| lk_value | output | NUM_RD*DATA_W | Lookup values, port 0 in the low bits |
| reg_we | output | 1 | Register write at retirement |
| reg_waddr | output | REG_W | Register number |
| reg_wdata | output | DATA_W | Register data |
| mem_we | output | 1 | Store release at retirement |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| flush_o | output | 1 | Buffer is emptied at the coming edge |
| redirect_valid | output | 1 | Mispredicted branch retires |
| redirect_pc | output | DATA_W | Correct fetch target |
| exc_valid | output | 1 | Precise exception raised |
| exc_tag | output | log2(DEPTH) | Tag of the faulting slot |

## Verification
The bench lets a younger result arrive before an older one. A buffer that retired out of order would write the younger register first. Stores receive their address and data in both orders, which catches a design that releases a store on data alone. Tags are pushed across the wrap point and the buffer is filled completely while a further request is held up. A design that confused full with empty, or overwrote the oldest slot, would show a wrong tag or a wrong register number at retirement. Mispredicted branches and faults are placed ahead of completed younger work. Any leak of that work to the register file, or a tail that resumes at the wrong tag, is reported.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [1:0] {
        KIND_ALU    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_REG,
        ACT_MEM,
        ACT_BR_OK,
        ACT_REDIRECT,
        ACT_FAULT
    } retire_act_e;

endpackage

// File: rtl/srb_ptrs.sv
module srb_ptrs #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_fire,
    input  logic                       retire_fire,
    input  logic                       flush,
    output logic [$clog2(DEPTH)-1:0]   head_idx,
    output logic [$clog2(DEPTH)-1:0]   tail_idx,
    output logic                       full,
    output logic                       empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (retire_fire) begin
            st_d.head = st_q.head + 1'b1;
        end
        if (flush) begin
            st_d.tail = st_d.head;
        end else if (alloc_fire) begin
            st_d.tail = st_q.tail + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_idx = st_q.head[IDX_W-1:0];
    assign tail_idx = st_q.tail[IDX_W-1:0];
    assign empty    = (st_q.head == st_q.tail);
    assign full     = (st_q.head[IDX_W] != st_q.tail[IDX_W]) &&
                      (st_q.head[IDX_W-1:0] == st_q.tail[IDX_W-1:0]);

endmodule

// File: rtl/srb_slots.sv
module srb_slots
    import srb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5,
    parameter int NUM_RD = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc_fire,
    input  logic [$clog2(DEPTH)-1:0]          alloc_idx,
    input  kind_e                             alloc_kind,
    input  logic [REG_W-1:0]                  alloc_dest,
    input  logic                              wb_valid,
    input  logic [$clog2(DEPTH)-1:0]          wb_idx,
    input  logic [DATA_W-1:0]                 wb_value,
    input  logic                              wb_fault,
    input  logic                              wb_mispred,
    input  logic                              sa_valid,
    input  logic [$clog2(DEPTH)-1:0]          sa_idx,
    input  logic [ADDR_W-1:0]                 sa_addr,
    input  logic                              retire_fire,
    input  logic                              flush,
    input  logic [$clog2(DEPTH)-1:0]          head_idx,
    input  logic [NUM_RD*$clog2(DEPTH)-1:0]   lk_idx,
    output logic [NUM_RD-1:0]                 lk_ready,
    output logic [NUM_RD*DATA_W-1:0]          lk_value,
    output logic                              head_valid,
    output kind_e                             head_kind,
    output logic [ADDR_W-1:0]                 head_dest,
    output logic [DATA_W-1:0]                 head_value,
    output logic                              head_ready,
    output logic                              head_fault,
    output logic                              head_mispred
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic [ADDR_W-1:0] dest;
        logic [DATA_W-1:0] value;
        logic              done;
        logic              addr_ok;
        logic              fault;
        logic              mispred;
    } slot_t;

    slot_t [DEPTH-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wb_valid && slot_q[wb_idx].valid) begin
            slot_d[wb_idx].value   = wb_value;
            slot_d[wb_idx].done    = 1'b1;
            slot_d[wb_idx].fault   = wb_fault;
            slot_d[wb_idx].mispred = wb_mispred;
        end
        if (sa_valid && slot_q[sa_idx].valid) begin
            slot_d[sa_idx].dest    = sa_addr;
            slot_d[sa_idx].addr_ok = 1'b1;
        end
        if (retire_fire) begin
            slot_d[head_idx].valid = 1'b0;
        end
        if (alloc_fire) begin
            slot_d[alloc_idx].valid   = 1'b1;
            slot_d[alloc_idx].kind    = alloc_kind;
            slot_d[alloc_idx].dest    = ADDR_W'(alloc_dest);
            slot_d[alloc_idx].value   = '0;
            slot_d[alloc_idx].done    = 1'b0;
            slot_d[alloc_idx].addr_ok = (alloc_kind != KIND_STORE);
            slot_d[alloc_idx].fault   = 1'b0;
            slot_d[alloc_idx].mispred = 1'b0;
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_d[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_lookup
            logic [IDX_W-1:0] idx;
            assign idx = lk_idx[p*IDX_W +: IDX_W];
            assign lk_ready[p] = slot_q[idx].valid && slot_q[idx].done;
            assign lk_value[p*DATA_W +: DATA_W] = slot_q[idx].value;
        end
    endgenerate

    assign head_valid   = slot_q[head_idx].valid;
    assign head_kind    = slot_q[head_idx].kind;
    assign head_dest    = slot_q[head_idx].dest;
    assign head_value   = slot_q[head_idx].value;
    assign head_ready   = slot_q[head_idx].done && slot_q[head_idx].addr_ok;
    assign head_fault   = slot_q[head_idx].fault;
    assign head_mispred = slot_q[head_idx].mispred;

endmodule

// File: rtl/srb_commit.sv
module srb_commit
    import srb_pkg::*;
(
    input  logic        head_valid,
    input  kind_e       head_kind,
    input  logic        head_ready,
    input  logic        head_fault,
    input  logic        head_mispred,
    output logic        retire_fire,
    output logic        flush,
    output logic        reg_we,
    output logic        mem_we,
    output logic        redirect_valid,
    output logic        exc_valid
);
    retire_act_e act;

    always_comb begin
        act = ACT_IDLE;
        if (head_valid && head_ready) begin
            if (head_fault) begin
                act = ACT_FAULT;
            end else begin
                unique case (head_kind)
                    KIND_ALU:    act = ACT_REG;
                    KIND_STORE:  act = ACT_MEM;
                    KIND_BRANCH: act = head_mispred ? ACT_REDIRECT : ACT_BR_OK;
                    default:     act = ACT_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        retire_fire    = 1'b0;
        flush          = 1'b0;
        reg_we         = 1'b0;
        mem_we         = 1'b0;
        redirect_valid = 1'b0;
        exc_valid      = 1'b0;
        unique case (act)
            ACT_REG: begin
                retire_fire = 1'b1;
                reg_we      = 1'b1;
            end
            ACT_MEM: begin
                retire_fire = 1'b1;
                mem_we      = 1'b1;
            end
            ACT_BR_OK: begin
                retire_fire = 1'b1;
            end
            ACT_REDIRECT: begin
                retire_fire    = 1'b1;
                flush          = 1'b1;
                redirect_valid = 1'b1;
            end
            ACT_FAULT: begin
                flush     = 1'b1;
                exc_valid = 1'b1;
            end
            default: begin
                retire_fire = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spec_retire_buffer.sv
module spec_retire_buffer
    import srb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5,
    parameter int NUM_RD = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc_valid,
    input  logic [1:0]                        alloc_kind,
    input  logic [REG_W-1:0]                  alloc_dest,
    output logic                              alloc_ready,
    output logic [$clog2(DEPTH)-1:0]          alloc_tag,
    input  logic                              wb_valid,
    input  logic [$clog2(DEPTH)-1:0]          wb_tag,
    input  logic [DATA_W-1:0]                 wb_value,
    input  logic                              wb_fault,
    input  logic                              wb_mispred,
    input  logic                              sa_valid,
    input  logic [$clog2(DEPTH)-1:0]          sa_tag,
    input  logic [ADDR_W-1:0]                 sa_addr,
    input  logic [NUM_RD*$clog2(DEPTH)-1:0]   lk_tag,
    output logic [NUM_RD-1:0]                 lk_ready,
    output logic [NUM_RD*DATA_W-1:0]          lk_value,
    output logic                              reg_we,
    output logic [REG_W-1:0]                  reg_waddr,
    output logic [DATA_W-1:0]                 reg_wdata,
    output logic                              mem_we,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic [DATA_W-1:0]                 mem_wdata,
    output logic                              flush_o,
    output logic                              redirect_valid,
    output logic [DATA_W-1:0]                 redirect_pc,
    output logic                              exc_valid,
    output logic [$clog2(DEPTH)-1:0]          exc_tag
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             alloc_fire;
    logic             retire_fire;
    logic             flush;
    logic             full;
    logic             empty;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;

    logic              head_valid;
    kind_e             head_kind;
    logic [ADDR_W-1:0] head_dest;
    logic [DATA_W-1:0] head_value;
    logic              head_ready;
    logic              head_fault;
    logic              head_mispred;

    assign alloc_ready = !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_idx;

    srb_ptrs #(
        .DEPTH (DEPTH)
    ) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_fire),
        .flush       (flush),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .full        (full),
        .empty       (empty)
    );

    srb_slots #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .NUM_RD (NUM_RD)
    ) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire   (alloc_fire),
        .alloc_idx    (tail_idx),
        .alloc_kind   (kind_e'(alloc_kind)),
        .alloc_dest   (alloc_dest),
        .wb_valid     (wb_valid),
        .wb_idx       (wb_tag),
        .wb_value     (wb_value),
        .wb_fault     (wb_fault),
        .wb_mispred   (wb_mispred),
        .sa_valid     (sa_valid),
        .sa_idx       (sa_tag),
        .sa_addr      (sa_addr),
        .retire_fire  (retire_fire),
        .flush        (flush),
        .head_idx     (head_idx),
        .lk_idx       (lk_tag),
        .lk_ready     (lk_ready),
        .lk_value     (lk_value),
        .head_valid   (head_valid),
        .head_kind    (head_kind),
        .head_dest    (head_dest),
        .head_value   (head_value),
        .head_ready   (head_ready),
        .head_fault   (head_fault),
        .head_mispred (head_mispred)
    );

    srb_commit u_commit (
        .head_valid     (head_valid),
        .head_kind      (head_kind),
        .head_ready     (head_ready),
        .head_fault     (head_fault),
        .head_mispred   (head_mispred),
        .retire_fire    (retire_fire),
        .flush          (flush),
        .reg_we         (reg_we),
        .mem_we         (mem_we),
        .redirect_valid (redirect_valid),
        .exc_valid      (exc_valid)
    );

    assign reg_waddr   = head_dest[REG_W-1:0];
    assign reg_wdata   = head_value;
    assign mem_addr    = head_dest;
    assign mem_wdata   = head_value;
    assign redirect_pc = head_value;
    assign exc_tag     = head_idx;
    assign flush_o     = flush;

endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             reg_we,
    input logic             mem_we,
    input logic             flush_o,
    input logic             redirect_valid,
    input logic             exc_valid
);
    logic [IDX_W-1:0] tag_next;
    assign tag_next = alloc_tag + 1'b1;

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (alloc_tag == $past(tag_next)));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !flush_o) |=> $stable(alloc_tag));

    // R5
    single_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, mem_we, redirect_valid, exc_valid}));

    // R9
    redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> flush_o);

    // R9
    post_flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!reg_we && !mem_we && !flush_o && alloc_ready));

    // R10
    fault_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (flush_o && !reg_we));

endmodule

bind spec_retire_buffer srb_checker #(
    .IDX_W ($clog2(DEPTH))
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid    (alloc_valid),
    .alloc_ready    (alloc_ready),
    .alloc_tag      (alloc_tag),
    .reg_we         (reg_we),
    .mem_we         (mem_we),
    .flush_o        (flush_o),
    .redirect_valid (redirect_valid),
    .exc_valid      (exc_valid)
);

// File: tb/spec_retire_buffer_tb.sv
`timescale 1ns/1ps
module spec_retire_buffer_tb;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int REG_W  = 5;
    localparam int NUM_RD = 2;
    localparam int IDX_W  = 3;

    localparam logic [1:0] K_ALU = 2'd0;
    localparam logic [1:0] K_ST  = 2'd1;
    localparam logic [1:0] K_BR  = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [1:0] alloc_kind = '0;
    logic [REG_W-1:0] alloc_dest = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_tag;
    logic wb_valid = 1'b0;
    logic [IDX_W-1:0] wb_tag = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic wb_fault = 1'b0;
    logic wb_mispred = 1'b0;
    logic sa_valid = 1'b0;
    logic [IDX_W-1:0] sa_tag = '0;
    logic [ADDR_W-1:0] sa_addr = '0;
    logic [NUM_RD*IDX_W-1:0] lk_tag = '0;
    logic [NUM_RD-1:0] lk_ready;
    logic [NUM_RD*DATA_W-1:0] lk_value;
    logic reg_we;
    logic [REG_W-1:0] reg_waddr;
    logic [DATA_W-1:0] reg_wdata;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic flush_o;
    logic redirect_valid;
    logic [DATA_W-1:0] redirect_pc;
    logic exc_valid;
    logic [IDX_W-1:0] exc_tag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spec_retire_buffer #(
        .DEPTH (DEPTH), .DATA_W (DATA_W), .ADDR_W (ADDR_W),
        .REG_W (REG_W), .NUM_RD (NUM_RD)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .alloc_valid (alloc_valid), .alloc_kind (alloc_kind),
        .alloc_dest (alloc_dest), .alloc_ready (alloc_ready),
        .alloc_tag (alloc_tag),
        .wb_valid (wb_valid), .wb_tag (wb_tag), .wb_value (wb_value),
        .wb_fault (wb_fault), .wb_mispred (wb_mispred),
        .sa_valid (sa_valid), .sa_tag (sa_tag), .sa_addr (sa_addr),
        .lk_tag (lk_tag), .lk_ready (lk_ready), .lk_value (lk_value),
        .reg_we (reg_we), .reg_waddr (reg_waddr), .reg_wdata (reg_wdata),
        .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .flush_o (flush_o), .redirect_valid (redirect_valid),
        .redirect_pc (redirect_pc), .exc_valid (exc_valid),
        .exc_tag (exc_tag)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(input logic [1:0] k, input logic [REG_W-1:0] d,
                            output logic [IDX_W-1:0] t);
        alloc_valid = 1'b1;
        alloc_kind  = k;
        alloc_dest  = d;
        t = alloc_tag;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic do_wb(input logic [IDX_W-1:0] t, input logic [DATA_W-1:0] v,
                         input bit f, input bit m);
        wb_valid = 1'b1;
        wb_tag = t;
        wb_value = v;
        wb_fault = f;
        wb_mispred = m;
        step();
        wb_valid = 1'b0;
        wb_fault = 1'b0;
        wb_mispred = 1'b0;
    endtask

    task automatic do_sa(input logic [IDX_W-1:0] t, input logic [ADDR_W-1:0] a);
        sa_valid = 1'b1;
        sa_tag = t;
        sa_addr = a;
        step();
        sa_valid = 1'b0;
    endtask

    task automatic test_reset();
        check(alloc_ready == 1'b1, "R1 alloc_ready", 64'(alloc_ready), 64'd1);
        check(alloc_tag == 0, "R1 alloc_tag", 64'(alloc_tag), 64'd0);
        check({reg_we, mem_we, flush_o, redirect_valid, exc_valid} == 5'b0,
              "R1 outputs idle",
              64'({reg_we, mem_we, flush_o, redirect_valid, exc_valid}), 64'd0);
    endtask

    task automatic test_alu_order();
        logic [IDX_W-1:0] t0, t1, t2;
        do_alloc(K_ALU, 5'd1, t0);
        do_alloc(K_ALU, 5'd2, t1);
        do_alloc(K_ALU, 5'd3, t2);
        check(t0 == 0 && t1 == 1 && t2 == 2, "R2 sequential tags",
              64'({t0, t1, t2}), 64'({3'd0, 3'd1, 3'd2}));
        do_wb(t2, 32'h30, 1'b0, 1'b0);
        check(reg_we == 1'b0, "R4 younger waits", 64'(reg_we), 64'd0);
        lk_tag = {t0, t2};
        #1;
        check(lk_ready[0] == 1'b1 && lk_value[DATA_W-1:0] == 32'h30,
              "R7 lookup ready", 64'(lk_value[DATA_W-1:0]), 64'h30);
        check(lk_ready[1] == 1'b0, "R7 lookup pending", 64'(lk_ready[1]), 64'd0);
        do_wb(t0, 32'h10, 1'b0, 1'b0);
        check(reg_we && reg_waddr == 5'd1 && reg_wdata == 32'h10, "R5 alu retire",
              64'({reg_we, reg_waddr, reg_wdata}), 64'({1'b1, 5'd1, 32'h10}));
        step();
        check(reg_we == 1'b0, "R4 head blocks", 64'(reg_we), 64'd0);
        do_wb(t1, 32'h20, 1'b0, 1'b0);
        check(reg_we && reg_waddr == 5'd2 && reg_wdata == 32'h20, "R4 second retire",
              64'({reg_waddr, reg_wdata}), 64'({5'd2, 32'h20}));
        step();
        check(reg_we && reg_waddr == 5'd3 && reg_wdata == 32'h30, "R4 third retire",
              64'({reg_waddr, reg_wdata}), 64'({5'd3, 32'h30}));
        step();
        check(reg_we == 1'b0 && alloc_tag == 3, "R2 drained",
              64'({reg_we, alloc_tag}), 64'({1'b0, 3'd3}));
    endtask

    task automatic test_store();
        logic [IDX_W-1:0] t;
        do_alloc(K_ST, 5'd0, t);
        do_wb(t, 32'hAB, 1'b0, 1'b0);
        check(mem_we == 1'b0, "R6 data only", 64'(mem_we), 64'd0);
        do_sa(t, 32'h100);
        check(mem_we && !reg_we && mem_addr == 32'h100 && mem_wdata == 32'hAB,
              "R6 store release", 64'({mem_we, reg_we, mem_addr, mem_wdata}),
              64'({1'b1, 1'b0, 32'h100, 32'hAB}));
        step();
        do_alloc(K_ST, 5'd0, t);
        do_sa(t, 32'h204);
        check(mem_we == 1'b0, "R6 address only", 64'(mem_we), 64'd0);
        do_wb(t, 32'hCD, 1'b0, 1'b0);
        check(mem_we && mem_addr == 32'h204 && mem_wdata == 32'hCD,
              "R6 store release addr first", 64'({mem_addr, mem_wdata}),
              64'({32'h204, 32'hCD}));
        step();
    endtask

    task automatic test_branch_ok();
        logic [IDX_W-1:0] tb, ta;
        do_alloc(K_BR, 5'd0, tb);
        do_alloc(K_ALU, 5'd7, ta);
        do_wb(ta, 32'h77, 1'b0, 1'b0);
        do_wb(tb, 32'h400, 1'b0, 1'b0);
        check({reg_we, mem_we, flush_o, redirect_valid} == 4'b0, "R8 branch silent",
              64'({reg_we, mem_we, flush_o, redirect_valid}), 64'd0);
        step();
        check(reg_we && reg_waddr == 5'd7 && reg_wdata == 32'h77, "R8 younger kept",
              64'({reg_we, reg_waddr, reg_wdata}), 64'({1'b1, 5'd7, 32'h77}));
        step();
    endtask

    task automatic test_mispredict();
        logic [IDX_W-1:0] tb, ta, tc;
        do_alloc(K_BR, 5'd0, tb);
        do_alloc(K_ALU, 5'd9, ta);
        do_alloc(K_ALU, 5'd10, tc);
        check(tb == 7 && ta == 0, "R2 tag wrap", 64'({tb, ta}), 64'({3'd7, 3'd0}));
        do_wb(ta, 32'h5, 1'b0, 1'b0);
        do_wb(tc, 32'h6, 1'b0, 1'b0);
        do_wb(tb, 32'h800, 1'b0, 1'b1);
        check(flush_o && redirect_valid && redirect_pc == 32'h800 && !reg_we,
              "R9 redirect", 64'({flush_o, redirect_valid, reg_we, redirect_pc}),
              64'({1'b1, 1'b1, 1'b0, 32'h800}));
        step();
        check(!reg_we && !flush_o && alloc_ready && alloc_tag == 0,
              "R9 after flush", 64'({reg_we, flush_o, alloc_ready, alloc_tag}),
              64'({1'b0, 1'b0, 1'b1, 3'd0}));
        lk_tag = {3'd1, 3'd0};
        #1;
        check(lk_ready == 2'b00, "R7 flushed lookup", 64'(lk_ready), 64'd0);
        step();
        check(reg_we == 1'b0, "R9 no late retire", 64'(reg_we), 64'd0);
    endtask

    task automatic test_fault();
        logic [IDX_W-1:0] t0, t1;
        do_alloc(K_ALU, 5'd4, t0);
        do_alloc(K_ALU, 5'd5, t1);
        do_wb(t1, 32'h11, 1'b0, 1'b0);
        do_wb(t0, 32'h99, 1'b1, 1'b0);
        check(exc_valid && exc_tag == t0 && flush_o && !reg_we, "R10 exception",
              64'({exc_valid, flush_o, reg_we, exc_tag}),
              64'({1'b1, 1'b1, 1'b0, t0}));
        step();
        check(!reg_we && !exc_valid && alloc_tag == t0, "R10 after exception",
              64'({reg_we, exc_valid, alloc_tag}), 64'({1'b0, 1'b0, t0}));
    endtask

    task automatic test_full();
        logic [IDX_W-1:0] t;
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(K_ALU, REG_W'(i + 1), t);
        end
        check(alloc_ready == 1'b0, "R3 full", 64'(alloc_ready), 64'd0);
        alloc_valid = 1'b1;
        alloc_kind = K_ALU;
        alloc_dest = 5'd30;
        step();
        alloc_valid = 1'b0;
        check(alloc_ready == 1'b0 && alloc_tag == 0, "R3 request ignored",
              64'({alloc_ready, alloc_tag}), 64'({1'b0, 3'd0}));
        for (int i = 0; i < DEPTH; i++) begin
            do_wb(IDX_W'(i), DATA_W'(32'h100 + i), 1'b0, 1'b0);
            check(reg_we && reg_waddr == REG_W'(i + 1) && reg_wdata == DATA_W'(32'h100 + i),
                  "R3 held slot intact", 64'({reg_we, reg_waddr, reg_wdata}),
                  64'({1'b1, REG_W'(i + 1), DATA_W'(32'h100 + i)}));
        end
        step();
        check(!reg_we && alloc_ready && alloc_tag == 0, "R3 drained",
              64'({reg_we, alloc_ready, alloc_tag}), 64'({1'b0, 1'b1, 3'd0}));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        test_reset();
        test_alu_order();
        test_store();
        test_branch_ok();
        test_mispredict();
        test_fault();
        test_full();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule